// File: doc/BRIEF.md
# I2C Status Read-Back Slave

This block is a read-only I2C target port. It lets a bus master fetch a status byte and up to two data bytes from a decoder core. The core presents the three bytes on parallel inputs. The port samples the bus clock and data lines with the system clock, cleans them, and detects start and stop conditions. It checks the address byte, acknowledges a match, and then shifts the bytes out in a fixed order. After each byte it samples the master's acknowledge.

The frame layout never changes. The status byte always comes first, then data byte 1, then data byte 2. A NACK from the master ends the transfer after any of these bytes. The block drives SDA only through an open-drain pull-down enable. At the stop that closes an acknowledged read, it gives the core a one-cycle pulse so the core can retire its data.

Top module: `sts_read_slave`

## Requirements
- R1: While reset is asserted and right after it is released, `sda_oe_o` is 0 (SDA released) and `frame_done_o` is 0.
- R2: A start (SDA falling while SCL is high) restarts address reception at any point in a frame, including in the middle of the address byte and after a completed read without a stop (repeated start).
- R3: An address byte equal to 0x29 (7-bit address 0x14 with the R/W bit at 1, sent MSB first) is acknowledged: SDA is held low for the whole ninth clock.
- R4: An address byte with a different address, or with the R/W bit at 0, is not acknowledged. SDA stays released (the master reads all ones) until the next start.
- R5: After the address acknowledge the slave sends the status byte, then data byte 1, then data byte 2, each MSB first. The next byte is sent only if the master answered the previous one with ACK (SDA low on the ninth clock).
- R6: After a master NACK (SDA high on the ninth clock), or an ACK after the third byte, SDA stays released until a start or stop.
- R7: `sda_oe_o` changes only while SCL is low.
- R8: The three byte inputs are captured at the address acknowledge. Changes to them during the frame do not alter the bytes of that frame.
- R9: `frame_done_o` pulses for exactly one cycle at the stop that ends a frame whose address was acknowledged. A stop after an unacknowledged address gives no pulse.
- R10: A pulse on SCL or SDA that lasts a single system clock cycle has no effect on the bus protocol.
- R11: A stop (SDA rising while SCL is high) returns the port to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| status_i | input | 8 | Status byte from the core |
| data1_i | input | 8 | First data byte from the core |
| data2_i | input | 8 | Second data byte from the core |
| frame_done_o | output | 1 | One-cycle pulse at the stop after an acknowledged read |

## Verification
The bench plays the master. It reads frames of three bytes, two bytes and one byte, so ordering and NACK termination can be told apart from a design that streams a fixed count. A read past the NACK shows that the slave has really let SDA go. Two further frames send a wrong address and a write-direction address; they separate address matching from R/W decoding and show that no completion pulse follows an unacknowledged frame. Other frames change the inputs after the acknowledge, abort the address byte with a start, issue a repeated start, and inject single-cycle glitches on both lines. These cover shadow capture, frame restart and input filtering.

// File: rtl/sts_rd_pkg.sv
package sts_rd_pkg;

   localparam int unsigned FRAME_BYTES = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_DEC,
      ST_ACK_OUT,
      ST_TX,
      ST_MACK,
      ST_MNEXT,
      ST_HOLD
   } rd_state_e;

   typedef struct packed {
      logic scl;
      logic sda;
      logic start;
      logic stop;
      logic rise;
      logic fall;
   } bus_ev_t;

endpackage

// File: rtl/sts_rd_filter.sv
module sts_rd_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_TAPS   = 3,
   parameter logic        RESET_VAL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{RESET_VAL}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end

   generate
      if (FILT_TAPS == 1) begin : g_bypass
         assign clean_o = sync_q[SYNC_STAGES-1];
      end else begin : g_majority
         logic [FILT_TAPS-1:0] win_q;
         logic                 vote_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q  <= {FILT_TAPS{RESET_VAL}};
               vote_q <= RESET_VAL;
            end else begin
               win_q  <= {win_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
               vote_q <= ($countones(win_q) > (FILT_TAPS / 2));
            end
         end
         assign clean_o = vote_q;
      end
   endgenerate

endmodule

// File: rtl/sts_rd_cond.sv
module sts_rd_cond
   import sts_rd_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_f,
   input  logic    sda_f,
   output bus_ev_t ev_o
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   always_comb begin
      ev_o.scl   = scl_f;
      ev_o.sda   = sda_f;
      ev_o.start = scl_q & scl_f & sda_q & ~sda_f;
      ev_o.stop  = scl_q & scl_f & ~sda_q & sda_f;
      ev_o.rise  = ~scl_q & scl_f;
      ev_o.fall  = scl_q & ~scl_f;
   end

endmodule

// File: rtl/sts_rd_fsm.sv
module sts_rd_fsm
   import sts_rd_pkg::*;
#(
   parameter int unsigned BYTE_W    = 8,
   parameter logic [7:0]  ADDR_BYTE = 8'h29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ev_t           ev,
   input  logic [BYTE_W-1:0] status_i,
   input  logic [BYTE_W-1:0] data1_i,
   input  logic [BYTE_W-1:0] data2_i,
   output logic              sda_oe_o,
   output logic              frame_done_o
);

   localparam int unsigned CNT_W = $clog2(BYTE_W);
   localparam int unsigned IDX_W = $clog2(FRAME_BYTES);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

   rd_state_e                              state_q;
   logic [CNT_W-1:0]                       bit_q;
   logic [IDX_W-1:0]                       idx_q, idx_nx;
   logic [BYTE_W-1:0]                      rx_q, tx_q;
   logic [FRAME_BYTES-1:0][BYTE_W-1:0]     shadow_q;
   logic                                   served_q, oe_q, done_q;

   assign idx_nx = idx_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bit_q    <= '0;
         idx_q    <= '0;
         rx_q     <= '0;
         tx_q     <= '0;
         shadow_q <= '0;
         served_q <= 1'b0;
         oe_q     <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (ev.start) begin
            state_q  <= ST_ADDR;
            bit_q    <= '0;
            rx_q     <= '0;
            oe_q     <= 1'b0;
            served_q <= 1'b0;
         end else if (ev.stop) begin
            state_q  <= ST_IDLE;
            oe_q     <= 1'b0;
            done_q   <= served_q;
            served_q <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR: if (ev.rise) begin
                  rx_q <= {rx_q[BYTE_W-2:0], ev.sda};
                  if (bit_q == LAST_BIT) begin
                     bit_q   <= '0;
                     state_q <= ST_ADDR_DEC;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
               ST_ADDR_DEC: if (ev.fall) begin
                  if (rx_q == BYTE_W'(ADDR_BYTE)) begin
                     oe_q     <= 1'b1;
                     shadow_q <= {data2_i, data1_i, status_i};
                     state_q  <= ST_ACK_OUT;
                  end else begin
                     state_q <= ST_HOLD;
                  end
               end
               ST_ACK_OUT: if (ev.fall) begin
                  served_q <= 1'b1;
                  idx_q    <= '0;
                  tx_q     <= shadow_q[0];
                  oe_q     <= ~shadow_q[0][BYTE_W-1];
                  bit_q    <= '0;
                  state_q  <= ST_TX;
               end
               ST_TX: if (ev.fall) begin
                  if (bit_q == LAST_BIT) begin
                     oe_q    <= 1'b0;
                     state_q <= ST_MACK;
                  end else begin
                     tx_q  <= tx_q << 1;
                     oe_q  <= ~tx_q[BYTE_W-2];
                     bit_q <= bit_q + 1'b1;
                  end
               end
               ST_MACK: if (ev.rise) begin
                  if (!ev.sda && idx_q != LAST_IDX) state_q <= ST_MNEXT;
                  else                              state_q <= ST_HOLD;
               end
               ST_MNEXT: if (ev.fall) begin
                  idx_q   <= idx_nx;
                  tx_q    <= shadow_q[idx_nx];
                  oe_q    <= ~shadow_q[idx_nx][BYTE_W-1];
                  bit_q   <= '0;
                  state_q <= ST_TX;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o     = oe_q;
   assign frame_done_o = done_q;

   // R3
   ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACK_OUT) |-> oe_q);

   // R6
   hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD) |-> !oe_q);

   // R7
   sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oe_q) |-> !ev.scl);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R9
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(ev.stop));

endmodule

// File: rtl/sts_read_slave.sv
module sts_read_slave
   import sts_rd_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h14,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_TAPS   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [BYTE_W-1:0] status_i,
   input  logic [BYTE_W-1:0] data1_i,
   input  logic [BYTE_W-1:0] data2_i,
   output logic              frame_done_o
);

   localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b1};

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_TAPS % 2 == 0) begin : g_bad_taps
         $error("FILT_TAPS must be odd");
      end
      if (BYTE_W != 8) begin : g_bad_width
         $error("BYTE_W must be 8 to match the address byte");
      end
   endgenerate

   logic [1:0] line_raw, line_clean;
   bus_ev_t    ev;

   assign line_raw = {sda_i, scl_i};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_line
         sts_rd_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_TAPS  (FILT_TAPS),
            .RESET_VAL  (1'b1)
         ) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (line_raw[g]),
            .clean_o(line_clean[g])
         );
      end
   endgenerate

   sts_rd_cond cond_i (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_f(line_clean[0]),
      .sda_f(line_clean[1]),
      .ev_o (ev)
   );

   sts_rd_fsm #(
      .BYTE_W   (BYTE_W),
      .ADDR_BYTE(ADDR_BYTE)
   ) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev          (ev),
      .status_i    (status_i),
      .data1_i     (data1_i),
      .data2_i     (data2_i),
      .sda_oe_o    (sda_oe_o),
      .frame_done_o(frame_done_o)
   );

endmodule

// File: tb/sts_read_slave_tb_top.sv
`timescale 1ns/1ps
module sts_read_slave_tb_top;

   localparam int H = 40;
   localparam int Q = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic [7:0] status_v = 8'h00, data1_v = 8'h00, data2_v = 8'h00;
   logic sda_oe, frame_done;
   logic sda_line;

   int checks = 0;
   int failures = 0;
   int done_cnt = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   sts_read_slave dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .sda_oe_o    (sda_oe),
      .status_i    (status_v),
      .data1_i     (data1_v),
      .data2_i     (data2_v),
      .frame_done_o(frame_done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Per-clock reference monitor: R7 edge rule and R9 pulse width
   logic oe_prev = 1'b0;
   logic fd_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_oe !== oe_prev)
            chk(scl_m == 1'b0, "R7 sda_oe changed while SCL high", int'(scl_m), 0);
         if (frame_done && fd_prev)
            chk(1'b0, "R9 frame_done wider than one cycle", 1, 0);
         if (frame_done) done_cnt++;
      end
      oe_prev = sda_oe;
      fd_prev = frame_done;
   end

   task automatic bus_start();
      sda_m = 1'b1; wclk(Q);
      scl_m = 1'b1; wclk(Q);
      sda_m = 1'b0; wclk(Q);
      scl_m = 1'b0; wclk(Q);
   endtask

   task automatic bus_stop();
      wclk(Q); sda_m = 1'b0; wclk(Q);
      scl_m = 1'b1; wclk(H);
      sda_m = 1'b1; wclk(H);
   endtask

   task automatic write_bit(input logic b, input bit glitch);
      wclk(Q / 2);
      if (glitch) begin scl_m = 1'b1; wclk(1); scl_m = 1'b0; end
      wclk(Q / 2);
      sda_m = b; wclk(Q);
      scl_m = 1'b1; wclk(Q);
      if (glitch && b) begin sda_m = 1'b0; wclk(1); sda_m = 1'b1; end
      wclk(Q);
      scl_m = 1'b0;
   endtask

   task automatic read_bit(output logic b);
      wclk(2);
      sda_m = 1'b1; wclk(H - 2);
      scl_m = 1'b1; wclk(Q);
      b = sda_line; wclk(Q);
      scl_m = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v, input bit glitch, output logic ack);
      for (int i = 7; i >= 0; i--) write_bit(v[i], glitch);
      read_bit(ack);
   endtask

   task automatic recv_byte(input logic master_ack, output logic [7:0] v);
      for (int i = 7; i >= 0; i--) begin
         logic b;
         read_bit(b);
         v[i] = b;
      end
      write_bit(master_ack, 1'b0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      logic       ack;
      logic [7:0] v;
      int         d0;
      byte unsigned exp_q[$];

      // R1 reset state
      wclk(3);
      chk(sda_oe == 1'b0, "R1 oe in reset", int'(sda_oe), 0);
      chk(frame_done == 1'b0, "R1 done in reset", int'(frame_done), 0);
      rst_n = 1'b1;
      wclk(10);
      chk(sda_oe == 1'b0, "R1 oe after reset", int'(sda_oe), 0);

      // Three-byte read: R3, R5, R9, R11
      status_v = 8'hA5; data1_v = 8'h3C; data2_v = 8'h81;
      exp_q = {8'hA5, 8'h3C, 8'h81};
      d0 = done_cnt;
      bus_start();
      send_byte(8'h29, 1'b0, ack);
      chk(ack == 1'b0, "R3 address 0x29 acked", int'(ack), 0);
      for (int k = 0; k < 3; k++) begin
         recv_byte((k == 2) ? 1'b1 : 1'b0, v);
         chk(v == exp_q[k], "R5 byte order", int'(v), int'(exp_q[k]));
      end
      bus_stop();
      chk(done_cnt == d0 + 1, "R9 one pulse after read", done_cnt - d0, 1);
      chk(sda_oe == 1'b0, "R11 idle after stop", int'(sda_oe), 0);

      // One-byte read then read past NACK: R5, R6
      status_v = 8'h5A;
      d0 = done_cnt;
      bus_start();
      send_byte(8'h29, 1'b0, ack);
      chk(ack == 1'b0, "R3 ack second frame", int'(ack), 0);
      recv_byte(1'b1, v);
      chk(v == 8'h5A, "R5 status first", int'(v), 8'h5A);
      recv_byte(1'b1, v);
      chk(v == 8'hFF, "R6 released after NACK", int'(v), 8'hFF);
      bus_stop();
      chk(done_cnt == d0 + 1, "R9 pulse after one-byte read", done_cnt - d0, 1);

      // Shadow capture: R8
      status_v = 8'h12; data1_v = 8'h34; data2_v = 8'h56;
      bus_start();
      send_byte(8'h29, 1'b0, ack);
      status_v = 8'hEE; data1_v = 8'hDD; data2_v = 8'hCC;
      recv_byte(1'b0, v);
      chk(v == 8'h12, "R8 status held", int'(v), 8'h12);
      recv_byte(1'b1, v);
      chk(v == 8'h34, "R8 data1 held", int'(v), 8'h34);
      bus_stop();

      // Wrong address: R4, R9
      d0 = done_cnt;
      bus_start();
      send_byte(8'h2B, 1'b0, ack);
      chk(ack == 1'b1, "R4 wrong address not acked", int'(ack), 1);
      recv_byte(1'b1, v);
      chk(v == 8'hFF, "R4 bus ignored", int'(v), 8'hFF);
      bus_stop();
      chk(done_cnt == d0, "R9 no pulse on unacked frame", done_cnt - d0, 0);

      // Write direction: R4
      d0 = done_cnt;
      bus_start();
      send_byte(8'h28, 1'b0, ack);
      chk(ack == 1'b1, "R4 write bit not acked", int'(ack), 1);
      bus_stop();
      chk(done_cnt == d0, "R9 no pulse after write addr", done_cnt - d0, 0);

      // Start inside the address byte, then repeated start: R2
      status_v = 8'h6B; data1_v = 8'h90;
      d0 = done_cnt;
      bus_start();
      for (int i = 0; i < 4; i++) write_bit(1'b1, 1'b0);
      bus_start();
      send_byte(8'h29, 1'b0, ack);
      chk(ack == 1'b0, "R2 start mid-address restarts", int'(ack), 0);
      recv_byte(1'b1, v);
      chk(v == 8'h6B, "R2 status after restart", int'(v), 8'h6B);
      bus_start();
      send_byte(8'h29, 1'b0, ack);
      chk(ack == 1'b0, "R2 repeated start acked", int'(ack), 0);
      recv_byte(1'b0, v);
      chk(v == 8'h6B, "R2 status again", int'(v), 8'h6B);
      recv_byte(1'b1, v);
      chk(v == 8'h90, "R5 data1 after repeated start", int'(v), 8'h90);
      bus_stop();
      chk(done_cnt == d0 + 1, "R9 single pulse at final stop", done_cnt - d0, 1);

      // Single-cycle glitches: R10
      status_v = 8'hC3;
      bus_start();
      send_byte(8'h29, 1'b1, ack);
      chk(ack == 1'b0, "R10 glitches ignored in address", int'(ack), 0);
      recv_byte(1'b1, v);
      chk(v == 8'hC3, "R10 status after glitches", int'(v), 8'hC3);
      bus_stop();

      wclk(20);
      finish_run();
   end

endmodule